// File: doc/BRIEF.md
# Register File with Program Counter Alias

This block is the register file of a small RISC core. It offers two read ports and one write port over eight 16-bit register indices. The last index is not backed by storage in the bank. It stands for the program counter, which sits in a fetch controller next to the bank and has its own incrementer. A read of that index returns the live counter value through the read multiplexer. A write to that index is a fetch redirect, so an add whose destination is the program counter acts as a jump without a separate branch opcode.

Instruction fetch is pipelined against a word-addressed program memory with one cycle of read latency. The fetch address is driven combinationally. When a redirect happens, the target goes straight onto the memory address in the same cycle. The instruction that was fetched one cycle earlier, in the branch shadow, is then handed to decode as a NOP with its valid flag low. A stall input holds the counter when decode cannot take a new word, and a redirect takes precedence over both stepping and stalling.

The write port is expected to be driven from write-back, one stage after an instruction leaves the slot. The read ports serve the instruction currently in the slot. Reset is asynchronous and active low, and its release is synchronised inside the block.

Top module: `pcalias_regfile`

## Requirements
- R1: While reset is applied, and while every cycle after reset has neither advanced nor redirected, `imem_addr` is 0, `instr_valid` is 0 and `instr_out` equals the NOP word (default 16'h0000).
- R2: A write to a general index (0 to 6) with `wr_en` high is returned by both read ports for that index from the next cycle onward.
- R3: A read of a general index in the same cycle as a write to that index returns the value held before the write.
- R4: A read of index 7 returns the current program counter. This is the word address that follows the instruction in the slot, or 0 after reset.
- R5: With `fetch_adv` high and no redirect, `imem_addr` equals the counter and the counter increases by 1. In the next cycle `instr_valid` is 1 and `instr_out` is the word that memory returns for that address.
- R6: With `fetch_adv` low and no redirect, the counter holds its value. In the next cycle `instr_valid` is 0 and `instr_out` is the NOP word.
- R7: A write with `wr_en` high to index 7 raises `redirect`, drives `imem_addr` to `wr_data` in the same cycle, leaves the counter at `wr_data` + 1, and changes no general register.
- R8: In a cycle in which `redirect` is high, `instr_valid` is 0 and `instr_out` is the NOP word.
- R9: When a redirect and `fetch_adv` are both high in the same cycle, the redirect decides the fetch address and the next counter value.
- R10: In the cycle after a redirect, `instr_valid` is 1 and `instr_out` is the memory word at the target, unless a new redirect is in progress.
- R11: Counter arithmetic wraps modulo 2^16, so a redirect to 16'hFFFF leaves a counter value of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 3 | Read port A index |
| rd_a_data | output | 16 | Read port A data |
| rd_b_idx | input | 3 | Read port B index |
| rd_b_data | output | 16 | Read port B data |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 3 | Write index (7 means program counter) |
| wr_data | input | 16 | Write data or redirect target |
| fetch_adv | input | 1 | Fetch may step to the next word |
| imem_addr | output | 16 | Program memory word address |
| imem_rdata | input | 16 | Program memory word, one cycle after address |
| instr_out | output | 16 | Instruction to decode (NOP when squashed) |
| instr_valid | output | 1 | `instr_out` holds a live instruction |
| redirect | output | 1 | A program counter write is redirecting fetch |

## Verification
The bench uses the default parameters: eight indices, 16-bit data, and the NOP word 16'h0000. With a 16-bit counter, a single redirect to 16'hFFFF brings the wrap within reach of a directed case. Random writes pick the counter index about one time in five. This produces back-to-back redirects, redirects during stalls, and same-index write/read collisions many times within a few thousand cycles. The memory model returns an address-dependent word, so a stale or shifted fetch shows up in `instr_out`.

// File: rtl/pcalias_pkg.sv
package pcalias_pkg;

  // What the fetch controller does with the counter in a given cycle.
  typedef enum logic [1:0] {
    FS_HOLD = 2'd0,
    FS_STEP = 2'd1,
    FS_JUMP = 2'd2
  } fetch_mode_e;

  // Selects the fetch mode; a redirect always outranks stepping.
  function automatic fetch_mode_e pick_mode(input logic redirect, input logic advance);
    if (redirect)     return FS_JUMP;
    else if (advance) return FS_STEP;
    else              return FS_HOLD;
  endfunction

endpackage

// File: rtl/pcalias_rst_sync.sv
module pcalias_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_sync_no = chain_q[STAGES-1];

endmodule

// File: rtl/pcalias_gpr_bank.sv
module pcalias_gpr_bank #(
  parameter int W      = 16,
  parameter int NREG   = 8,
  parameter int PC_IDX = NREG - 1,
  localparam int IW    = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [IW-1:0]            wr_idx,
  input  logic [W-1:0]             wr_data,
  output logic [NREG-1:0][W-1:0]   bank
);

  logic [NREG-1:0] ent_we;

  // Per-entry write enables; the aliased index never gets one.
  always_comb begin
    ent_we = '0;
    for (int i = 0; i < NREG; i++) begin
      if (i != PC_IDX) ent_we[i] = wr_en && (wr_idx == IW'(i));
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_ent
    if (g == PC_IDX) begin : g_alias
      assign bank[g] = '0;
    end else begin : g_store
      logic [W-1:0] ent_q;
      // Datapath storage: no reset, clock enable from the decode above.
      always_ff @(posedge clk) begin
        if (ent_we[g]) ent_q <= wr_data;
      end
      assign bank[g] = ent_q;
    end
  end

endmodule

// File: rtl/pcalias_rdport.sv
module pcalias_rdport #(
  parameter int W      = 16,
  parameter int NREG   = 8,
  parameter int PC_IDX = NREG - 1,
  localparam int IW    = $clog2(NREG)
) (
  input  logic [IW-1:0]           idx,
  input  logic [NREG-1:0][W-1:0]  bank,
  input  logic [W-1:0]            pc,
  output logic [W-1:0]            data
);

  logic hit_pc;

  always_comb begin
    hit_pc = (idx == IW'(PC_IDX));
    data   = hit_pc ? pc : bank[idx];
  end

endmodule

// File: rtl/pcalias_fetch.sv
module pcalias_fetch
  import pcalias_pkg::*;
#(
  parameter int          W   = 16,
  parameter logic [W-1:0] NOP = '0
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         advance,
  input  logic         redirect,
  input  logic [W-1:0] target,
  input  logic [W-1:0] imem_rdata,
  output logic [W-1:0] imem_addr,
  output logic [W-1:0] pc_q,
  output logic [W-1:0] instr_out,
  output logic         instr_valid
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  fetch_mode_e mode;
  logic [W-1:0] pc_base;
  logic [W-1:0] pc_d;
  logic         pc_en;
  logic         slot_d;
  logic         slot_q;

  // Next-state: pick fetch address and counter update.
  always_comb begin
    mode    = pick_mode(redirect, advance);
    pc_base = (mode == FS_JUMP) ? target : pc_q;
    pc_d    = pc_base + ONE;
    pc_en   = (mode != FS_HOLD);
    slot_d  = pc_en;
  end

  assign imem_addr = pc_base;

  // Counter and slot-valid registers.
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= '0;
      slot_q <= 1'b0;
    end else begin
      if (pc_en) pc_q <= pc_d;
      slot_q <= slot_d;
    end
  end

  // Shadow squash: the word in the slot is dropped while a redirect runs.
  always_comb begin
    instr_valid = slot_q && !redirect;
    instr_out   = instr_valid ? imem_rdata : NOP;
  end

endmodule

// File: rtl/pcalias_regfile.sv
module pcalias_regfile
  import pcalias_pkg::*;
#(
  parameter int           W      = 16,
  parameter int           NREG   = 8,
  parameter int           PC_IDX = NREG - 1,
  parameter logic [W-1:0] NOP    = '0,
  localparam int          IW     = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rd_a_idx,
  output logic [W-1:0]  rd_a_data,
  input  logic [IW-1:0] rd_b_idx,
  output logic [W-1:0]  rd_b_data,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  input  logic          fetch_adv,
  output logic [W-1:0]  imem_addr,
  input  logic [W-1:0]  imem_rdata,
  output logic [W-1:0]  instr_out,
  output logic          instr_valid,
  output logic          redirect
);

  localparam int NRD = 2;

  logic                   rst_sync_n;
  logic [NREG-1:0][W-1:0] bank;
  logic [W-1:0]           pc_q;
  logic [NRD-1:0][IW-1:0] rd_idx_arr;
  logic [NRD-1:0][W-1:0]  rd_data_arr;

  assign redirect = wr_en && (wr_idx == IW'(PC_IDX));

  pcalias_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_ni      (rst_n),
    .rst_sync_no (rst_sync_n)
  );

  pcalias_gpr_bank #(.W(W), .NREG(NREG), .PC_IDX(PC_IDX)) u_bank (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .bank    (bank)
  );

  pcalias_fetch #(.W(W), .NOP(NOP)) u_fetch (
    .clk         (clk),
    .rst_ni      (rst_sync_n),
    .advance     (fetch_adv),
    .redirect    (redirect),
    .target      (wr_data),
    .imem_rdata  (imem_rdata),
    .imem_addr   (imem_addr),
    .pc_q        (pc_q),
    .instr_out   (instr_out),
    .instr_valid (instr_valid)
  );

  assign rd_idx_arr[0] = rd_a_idx;
  assign rd_idx_arr[1] = rd_b_idx;

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    pcalias_rdport #(.W(W), .NREG(NREG), .PC_IDX(PC_IDX)) u_rd (
      .idx  (rd_idx_arr[p]),
      .bank (bank),
      .pc   (pc_q),
      .data (rd_data_arr[p])
    );
  end

  assign rd_a_data = rd_data_arr[0];
  assign rd_b_data = rd_data_arr[1];

endmodule

// File: rtl/pcalias_regfile_chk.sv
module pcalias_regfile_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_ni,
  input logic         redirect,
  input logic         fetch_adv,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] imem_addr,
  input logic         instr_valid,
  input logic [W-1:0] pc_q
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  assert_jump_addr_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    redirect |-> imem_addr == wr_data);

  assert_jump_next_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    redirect |=> pc_q == $past(wr_data) + ONE);

  assert_shadow_squash_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    redirect |-> !instr_valid);

  assert_step_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (fetch_adv && !redirect) |=> pc_q == $past(pc_q) + ONE);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (!fetch_adv && !redirect) |=> (pc_q == $past(pc_q)) && (redirect || !instr_valid));

  assert_target_live_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    redirect |=> (instr_valid || redirect));

endmodule

bind pcalias_regfile pcalias_regfile_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_ni      (rst_sync_n),
  .redirect    (redirect),
  .fetch_adv   (fetch_adv),
  .wr_data     (wr_data),
  .imem_addr   (imem_addr),
  .instr_valid (instr_valid),
  .pc_q        (pc_q)
);

// File: tb/tb_pcalias_regfile.sv
module tb_pcalias_regfile;

  localparam logic [15:0] NOPW = 16'h0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [15:0] rd_a_data, rd_b_data, wr_data;
  logic        wr_en, fetch_adv;
  logic [15:0] imem_addr, imem_rdata, instr_out;
  logic        instr_valid, redirect;

  int n_chk = 0;
  int n_bad = 0;

  // Bench model state.
  logic [15:0] m_pc, m_slot_addr;
  logic        m_slot_vld;
  logic [15:0] m_reg [0:6];
  int          m_prev;   // 0 step, 1 hold, 2 jump
  string       pc_tag = "R4";

  always #4 clk = ~clk;

  pcalias_regfile dut (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .fetch_adv(fetch_adv), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .instr_out(instr_out), .instr_valid(instr_valid), .redirect(redirect)
  );

  function automatic logic [15:0] memword(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'hA5C3;
  endfunction

  // One-cycle synchronous program memory.
  always @(posedge clk) imem_rdata <= memword(imem_addr);

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] exp_rd(input logic [2:0] i);
    return (i == 3'd7) ? m_pc : m_reg[i];
  endfunction

  task automatic step(input logic adv, input logic we, input logic [2:0] wi,
                      input logic [15:0] wd, input logic [2:0] ra, input logic [2:0] rb);
    logic        rdr;
    logic        ev;
    string       tv;
    @(negedge clk);
    fetch_adv = adv; wr_en = we; wr_idx = wi; wr_data = wd;
    rd_a_idx = ra; rd_b_idx = rb;
    #1;
    rdr = we && (wi == 3'd7);
    ev  = m_slot_vld && !rdr;
    // read ports
    chk((ra == 3'd7) ? pc_tag : ((we && wi == ra) ? "R3" : "R2"), rd_a_data, exp_rd(ra));
    chk((rb == 3'd7) ? pc_tag : ((we && wi == rb) ? "R3" : "R2"), rd_b_data, exp_rd(rb));
    // fetch address
    chk(rdr ? (adv ? "R9" : "R7") : (adv ? "R5" : "R6"), imem_addr, rdr ? wd : m_pc);
    chk("R7", {15'd0, redirect}, {15'd0, rdr});
    // slot output
    tv = rdr ? "R8" : (m_prev == 2 ? "R10" : (m_prev == 1 ? "R6" : "R5"));
    chk(tv, {15'd0, instr_valid}, {15'd0, ev});
    chk(tv, instr_out, ev ? memword(m_slot_addr) : NOPW);
    // model update
    if (rdr) begin
      m_slot_addr = wd; m_pc = wd + 16'd1; m_slot_vld = 1'b1; m_prev = 2;
    end else if (adv) begin
      m_slot_addr = m_pc; m_pc = m_pc + 16'd1; m_slot_vld = 1'b1; m_prev = 0;
    end else begin
      m_slot_vld = 1'b0; m_prev = 1;
    end
    if (we && wi != 3'd7) m_reg[wi] = wd;
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240417));
    rst_n = 1'b0; fetch_adv = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_data = '0;
    rd_a_idx = 3'd7; rd_b_idx = 3'd7;
    m_pc = '0; m_slot_vld = 1'b0; m_slot_addr = '0; m_prev = 1;
    for (int i = 0; i < 7; i++) m_reg[i] = 'x;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", imem_addr, 16'h0000);
    chk("R1", {15'd0, instr_valid}, 16'h0000);
    chk("R1", instr_out, NOPW);
    chk("R1", rd_a_data, 16'h0000);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 3'd0, 16'h0, 3'd7, 3'd7);

    // Load all general registers (R2), reading only the counter (R4).
    for (int i = 0; i < 7; i++) step(1'b0, 1'b1, 3'(i), 16'h1111 * 16'(i + 1), 3'd7, 3'd7);
    for (int i = 0; i < 7; i++) step(1'b1, 1'b0, 3'd0, 16'h0, 3'(i), 3'(6 - i));

    // R3: same-cycle write and read of one index.
    step(1'b1, 1'b1, 3'd3, 16'hBEEF, 3'd3, 3'd3);
    step(1'b1, 1'b0, 3'd0, 16'h0, 3'd3, 3'd7);

    // R9: redirect while advancing, then R10.
    step(1'b1, 1'b1, 3'd7, 16'h0400, 3'd0, 3'd7);
    step(1'b1, 1'b0, 3'd0, 16'h0, 3'd7, 3'd1);
    // R7: redirect while stalled.
    step(1'b0, 1'b1, 3'd7, 16'h0800, 3'd2, 3'd7);
    step(1'b0, 1'b0, 3'd0, 16'h0, 3'd7, 3'd7);
    // R6: stall twice.
    step(1'b0, 1'b0, 3'd0, 16'h0, 3'd7, 3'd4);
    // Back-to-back redirects.
    step(1'b1, 1'b1, 3'd7, 16'h1234, 3'd7, 3'd5);
    step(1'b1, 1'b1, 3'd7, 16'h2345, 3'd7, 3'd6);
    // R11: wrap from 16'hFFFF.
    step(1'b1, 1'b1, 3'd7, 16'hFFFF, 3'd7, 3'd0);
    pc_tag = "R11";
    step(1'b1, 1'b0, 3'd0, 16'h0, 3'd7, 3'd7);
    pc_tag = "R4";

    // Random phase.
    for (int k = 0; k < 4000; k++) begin
      logic        adv, we;
      logic [2:0]  wi;
      adv = ($urandom_range(0, 3) != 0);
      we  = ($urandom_range(0, 1) == 1);
      wi  = ($urandom_range(0, 4) == 0) ? 3'd7 : 3'($urandom_range(0, 6));
      step(adv, we, wi, 16'($urandom()), 3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)));
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule